// File: doc/BRIEF.md
# Parallel-Bus DAC Register Core

This block is the digital front end of a 16-bit voltage-output converter that sits on a shared parallel bus. It keeps two registers. The staging register is loaded from the bus and can be read back on the same pins. The output register holds the code that the converter turns into a voltage, and this code is presented on a plain 16-bit output. All bus controls are active low and asynchronous. They are brought into the system clock domain through two-flop synchronizers before they act.

A bus master writes a code by pulling chip-select low with the direction line low. The code is taken when chip-select returns high, using the bus value captured at that moment. With the direction line high, chip-select low drives the staging register back onto the bus. A separate load strobe copies the staging register into the output register. Tying the load strobes of several converters together lets them change their outputs together.

A clear strobe forces the output register to a reset code. The code is all-zeros or mid-scale (only the top bit set), picked by the direction line during the clear. All-zeros is 0 V for a unipolar range, and mid-scale is 0 V for a bipolar range. A parameter reverses which direction level picks which code.

Top module: `pdac_regcore`

## Requirements
- R1: After reset the output code is 0x0000, the staging register reads back 0x0000, and the bus drive enable is low.
- R2: A cycle with chip-select low and direction low loads the staging register with the bus value present when chip-select returns high.
- R3: While chip-select is low and direction is high, the block drives the staging register onto the bus and the bus drive enable is high.
- R4: A low on the load strobe copies the staging register into the output code.
- R5: A low on the clear strobe while direction is low sets the output code to 0x0000 (default mapping).
- R6: A low on the clear strobe while direction is high sets the output code to 0x8000 (bit 15 set, all others clear; default mapping).
- R7: When the clear and load strobes are low together, the clear code wins.
- R8: A clear leaves the staging register unchanged, as seen by a later readback.
- R9: The bus drive enable is low, and the bus is released, whenever the block is not being read, including during a write.
- R10: Without a load or clear strobe the output code holds, and writes to the staging register do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| rw | input | 1 | Direction: 0 write, 1 read; also picks the clear code |
| ldac_n | input | 1 | Load strobe, active low: staging to output |
| clr_n | input | 1 | Clear strobe, active low |
| bus_io | inout | 16 | Shared data bus |
| bus_drive | output | 1 | High while the block drives bus_io |
| dac_code | output | 16 | Code held in the output register |

## Verification
The assertions rely on two things about the bus. The bus value must stay stable through the synchronizer delay around the rising edge of chip-select. The direction line must not change while chip-select is low or while a clear is active. The stimulus tasks keep every control level and bus value in place for four clock cycles on each side of each strobe edge. The bench drives the bus only during writes and releases it before it starts a read. It changes the load and clear strobes on the same clock edge when it tests their priority.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

  // Synchronized view of the asynchronous bus controls.
  typedef struct packed {
    logic cs_n;
    logic rw;
    logic ldac_n;
    logic clr_n;
  } ctl_t;

  // True when a clear should produce mid-scale rather than zero.
  function automatic logic clear_is_mid(input logic rw_lvl, input logic swap);
    return rw_lvl ^ swap;
  endfunction

  // Full clear code for a register of width w (w <= 32).
  function automatic logic [31:0] clear_code(input logic rw_lvl, input logic swap,
                                             input int unsigned w);
    logic [31:0] v;
    v = '0;
    if (clear_is_mid(rw_lvl, swap)) v[w-1] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/pdac_sync.sv
module pdac_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/pdac_in_latch.sv
module pdac_in_latch #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_s,
  input  logic         rw_s,
  input  logic [W-1:0] bus_in,
  output logic         wr_fire,
  output logic         oe,
  output logic [W-1:0] latch_q
);
  logic         cs_q;
  logic [W-1:0] dpipe [STAGES];

  // Data pipeline matches the control synchronizer depth.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dpipe[0] <= '0;
    else        dpipe[0] <= bus_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_dpipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dpipe[s] <= '0;
      else        dpipe[s] <= dpipe[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_s;
  end

  // Write commits on the deasserting edge of chip-select.
  assign wr_fire = cs_s & ~cs_q & ~rw_s;
  assign oe      = ~cs_s & rw_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (wr_fire) latch_q <= dpipe[STAGES-1];
  end

  p_wr_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> latch_q == $past(dpipe[STAGES-1]));

  p_no_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(latch_q));
endmodule

// File: rtl/pdac_out_latch.sv
module pdac_out_latch #(
  parameter int unsigned W    = 16,
  parameter logic        SWAP = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ldac_fire,
  input  logic         clr_fire,
  input  logic         clr_rw,
  input  logic [W-1:0] src,
  output logic [W-1:0] dac_q
);
  logic [31:0]  clr_full;
  logic [W-1:0] clr_val;

  assign clr_full = pdac_pkg::clear_code(clr_rw, SWAP, W);
  assign clr_val  = clr_full[W-1:0];

  // Clear outranks load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dac_q <= '0;
    else if (clr_fire)  dac_q <= clr_val;
    else if (ldac_fire) dac_q <= src;
  end

  p_ldac_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_fire && !clr_fire) |=> dac_q == $past(src));

  p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && (clr_rw == SWAP)) |=> dac_q == '0);

  p_clr_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && (clr_rw != SWAP)) |=> (dac_q[W-1] && $countones(dac_q) == 1));

  p_dac_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ldac_fire && !clr_fire) |=> $stable(dac_q));
endmodule

// File: rtl/pdac_regcore.sv
module pdac_regcore #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        CLR_SWAP    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              ldac_n,
  input  logic              clr_n,
  inout  wire  [DATA_W-1:0] bus_io,
  output logic              bus_drive,
  output logic [DATA_W-1:0] dac_code
);
  localparam int unsigned CTL_W = $bits(pdac_pkg::ctl_t);

  pdac_pkg::ctl_t    ctl_raw, ctl_s;
  logic [CTL_W-1:0]  ctl_bits;
  logic              wr_fire, ldac_fire, clr_fire, oe;
  logic [DATA_W-1:0] in_q;

  assign ctl_raw = '{cs_n: cs_n, rw: rw, ldac_n: ldac_n, clr_n: clr_n};

  pdac_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ctl_raw), .q_sync(ctl_bits));

  assign ctl_s     = ctl_bits;
  assign ldac_fire = ~ctl_s.ldac_n;
  assign clr_fire  = ~ctl_s.clr_n;

  pdac_in_latch #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_in (
    .clk(clk), .rst_n(rst_n), .cs_s(ctl_s.cs_n), .rw_s(ctl_s.rw),
    .bus_in(bus_io), .wr_fire(wr_fire), .oe(oe), .latch_q(in_q));

  pdac_out_latch #(.W(DATA_W), .SWAP(CLR_SWAP)) u_out (
    .clk(clk), .rst_n(rst_n), .ldac_fire(ldac_fire), .clr_fire(clr_fire),
    .clr_rw(ctl_s.rw), .src(in_q), .dac_q(dac_code));

  assign bus_io    = oe ? in_q : 'z;
  assign bus_drive = oe;

  p_clr_keeps_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && !wr_fire) |=> $stable(in_q));

  p_no_drive_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !bus_drive);

  p_write_spares_dac_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !ldac_fire && !clr_fire) |=> $stable(dac_code));
endmodule

// File: tb/pdac_regcore_tb.sv
`timescale 1ns/1ps
module pdac_regcore_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rw = 1'b1, ldac_n = 1'b1, clr_n = 1'b1;
  logic        tb_en = 1'b0;
  logic [15:0] tb_val = '0;
  wire  [15:0] bus_w;
  logic        bus_drive;
  logic [15:0] dac_code;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;
  logic [15:0] exp_in = '0, exp_dac = '0;

  always #2 clk = ~clk;

  assign bus_w = tb_en ? tb_val : 'z;

  pdac_regcore dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .ldac_n(ldac_n),
    .clr_n(clr_n), .bus_io(bus_w), .bus_drive(bus_drive), .dac_code(dac_code));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] v);
    @(negedge clk);
    rw = 1'b0; tb_val = v; tb_en = 1'b1;
    wait_n(1);
    cs_n = 1'b0;
    wait_n(4);
    chk("R9 no drive during write", {15'd0, bus_drive}, 16'd0);
    cs_n = 1'b1;
    wait_n(4);
    tb_en = 1'b0; rw = 1'b1;
    wait_n(2);
    exp_in = v;
    chk("R10 write leaves output", dac_code, exp_dac);
  endtask

  task automatic do_read(input string req);
    @(negedge clk);
    rw = 1'b1; cs_n = 1'b0;
    wait_n(4);
    chk("R3 drive enable on read", {15'd0, bus_drive}, 16'd1);
    chk(req, bus_w, exp_in);
    cs_n = 1'b1;
    wait_n(4);
    chk("R9 released after read", {15'd0, bus_drive}, 16'd0);
  endtask

  task automatic do_ldac();
    @(negedge clk);
    ldac_n = 1'b0;
    wait_n(4);
    ldac_n = 1'b1;
    wait_n(4);
    exp_dac = exp_in;
    chk("R4 load copies staging", dac_code, exp_dac);
  endtask

  task automatic do_clr(input logic lvl, input string req);
    @(negedge clk);
    rw = lvl;
    wait_n(4);
    clr_n = 1'b0;
    wait_n(4);
    clr_n = 1'b1;
    wait_n(4);
    rw = 1'b1;
    exp_dac = lvl ? 16'h8000 : 16'h0000;
    chk(req, dac_code, exp_dac);
  endtask

  task automatic do_both_r7();
    @(negedge clk);
    rw = 1'b0;
    wait_n(4);
    clr_n = 1'b0; ldac_n = 1'b0;
    wait_n(4);
    clr_n = 1'b1; ldac_n = 1'b1;
    wait_n(4);
    rw = 1'b1;
    exp_dac = 16'h0000;
    chk("R7 clear beats load", dac_code, exp_dac);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    chk("R1 reset output", dac_code, 16'h0000);
    chk("R1 reset drive enable", {15'd0, bus_drive}, 16'd0);
    do_read("R1 reset readback");

    do_write(16'hA5C3);
    chk("R2 write no output change", dac_code, 16'h0000);
    do_read("R2 R3 readback A5C3");
    do_ldac();

    do_write(16'h1234);
    chk("R10 output holds A5C3", dac_code, 16'hA5C3);
    do_read("R2 readback 1234");
    do_clr(1'b0, "R5 clear to zero");
    do_read("R8 staging kept after clear");
    do_clr(1'b1, "R6 clear to mid-scale");
    do_read("R8 staging kept after mid clear");
    do_ldac();

    do_write(16'hFFFF);
    chk("R10 output holds 1234", dac_code, 16'h1234);
    do_both_r7();
    do_read("R8 staging FFFF after priority clear");
    do_ldac();
    chk("R4 load FFFF", dac_code, 16'hFFFF);

    do_write(16'h0000);
    do_read("R2 readback zero");
    wait_n(8);
    chk("R10 idle hold", dac_code, 16'hFFFF);
    do_ldac();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule